// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies even parity for a multiplexed address/data bus and its command/byte-enable lines. The bus is split into lanes; each lane has its own parity line, and the ones across a lane's address/data bits, its command/byte-enable bits and its parity bit must add up to an even number. Lane 0 is always in use. The upper lanes join in only for wide (64-bit style) transfers.

Role inputs tell the block what is on the bus in each cycle. When this agent sources an address or data phase, the block drives the parity for that phase one clock later. When another agent sources a phase that this agent receives, the block adds the incoming parity, which arrives one clock after the phase, and reports a mismatch. Errors found on data phases and errors found on address phases go to two separate open-drain error lines, modelled here as active-high output enables. Each error line has its own enable bit from the configuration registers. The caller sequences the bus protocol.

Top module: `bus_parity_unit`

## Requirements
- R1: In the cycle after a cycle with `src_addr` or `src_data` high, `par_out[0]` equals the XOR of lane 0's `ad` and `cbe` bits from that earlier cycle, so the lane's total count of ones is even.
- R2: `par_oe[0]` is high exactly in the cycle that follows a cycle with `src_addr` or `src_data` high, and is low in every other cycle.
- R3: For lanes above 0, `par_oe[l]` is high only when lane 0 drives and `wide` was high in the sourced cycle. When it is high, `par_out[l]` is the XOR of that lane's `ad` and `cbe` bits.
- R4: After a cycle with `chk_data` high, the parity sum is formed from that cycle's `ad`/`cbe` and the next cycle's `par_in`. If the sum is odd, `perr_oe` is high in the second cycle after the data phase, for that one cycle only.
- R5: A parity mismatch on a phase marked by `chk_addr` raises `serr_oe` with the same two-cycle timing as R4, and never raises `perr_oe`.
- R6: If `perr_en` is low in the cycle after the data phase (the cycle that carries its parity), no data error is reported.
- R7: `serr_en` masks only address errors, and does so independently of `perr_en`, with the same timing as R6.
- R8: While `rst` is high and in the first cycle after it, `par_oe`, `perr_oe` and `serr_oe` are all low.
- R9: For a checked phase whose `wide` input was low, a mismatch on an upper lane is ignored and causes no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all signals are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ad | input | LANE_W*LANES | Address/data bus value seen in this cycle |
| cbe | input | LANE_W/8*LANES | Command/byte-enable bus value seen in this cycle |
| par_in | input | LANES | Parity lines as sampled, one per lane |
| src_addr | input | 1 | This agent is sourcing an address phase this cycle |
| src_data | input | 1 | This agent is sourcing a data phase this cycle |
| chk_addr | input | 1 | An address phase from another agent is to be checked |
| chk_data | input | 1 | A data phase received by this agent is to be checked |
| wide | input | 1 | The current phase uses the upper lanes as well |
| perr_en | input | 1 | Configuration bit that enables data-error reporting |
| serr_en | input | 1 | Configuration bit that enables address-error reporting |
| par_out | output | LANES | Generated parity, one per lane |
| par_oe | output | LANES | Drive enable for each parity line |
| perr_oe | output | 1 | Pulls the data-error line low while high |
| serr_oe | output | 1 | Pulls the address-error line low while high |

## Verification
The bench builds the block with 8-bit lanes and two lanes. Each lane then carries nine protected bits, so a sweep of all 512 lane-0 patterns, with a second pattern on the upper lane, covers every parity value. Along the same sweep the bench varies the error injected on each lane, the wide flag, the phase kind (address or data) and both enable bits. This exercises lane masking, the routing of errors to the two lines and the one-cycle report pulse, and all expected values come from simple XORs in the bench.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    localparam int unsigned DEF_LANE_W  = 32;
    localparam int unsigned DEF_LANES   = 2;
    localparam int unsigned MAX_SPAN    = 72;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ADDR = 2'b01,
        PH_DATA = 2'b10
    } phase_kind_t;

    // Odd-count detector over a zero-extended lane slice.
    function automatic logic odd_ones(input logic [MAX_SPAN-1:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/bpar_gen.sv
module bpar_gen
    import bpar_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_any,
    input  logic             wide,
    input  logic [LANES-1:0] lane_sum,
    output logic [LANES-1:0] par_out,
    output logic [LANES-1:0] par_oe
);

    logic drv_q;
    logic wide_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q   <= 1'b0;
            wide_q  <= 1'b0;
            par_out <= '0;
        end else begin
            drv_q   <= src_any;
            wide_q  <= wide;
            par_out <= lane_sum;
        end
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_oe
            if (l == 0) begin : g_base
                assign par_oe[l] = drv_q;
            end else begin : g_upper
                assign par_oe[l] = drv_q & wide_q;
            end
        end
    endgenerate

endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
    import bpar_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic             wide,
    input  logic [LANES-1:0] lane_sum,
    input  logic [LANES-1:0] par_in,
    input  logic             enable,
    output logic             err_oe
);

    logic             pend_q;
    logic             wide_q;
    logic [LANES-1:0] sum_q;
    logic [LANES-1:0] mask;
    logic [LANES-1:0] bad;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_mask
            if (l == 0) begin : g_base
                assign mask[l] = 1'b1;
            end else begin : g_upper
                assign mask[l] = wide_q;
            end
        end
    endgenerate

    assign bad = (sum_q ^ par_in) & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            wide_q <= 1'b0;
            sum_q  <= '0;
            err_oe <= 1'b0;
        end else begin
            pend_q <= sample;
            wide_q <= wide;
            sum_q  <= lane_sum;
            err_oe <= pend_q & enable & (|bad);
        end
    end

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bpar_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned LANES  = DEF_LANES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LANE_W*LANES-1:0]       ad,
    input  logic [(LANE_W/8)*LANES-1:0]   cbe,
    input  logic [LANES-1:0]              par_in,
    input  logic                          src_addr,
    input  logic                          src_data,
    input  logic                          chk_addr,
    input  logic                          chk_data,
    input  logic                          wide,
    input  logic                          perr_en,
    input  logic                          serr_en,
    output logic [LANES-1:0]              par_out,
    output logic [LANES-1:0]              par_oe,
    output logic                          perr_oe,
    output logic                          serr_oe
);

    localparam int unsigned CB_W = LANE_W / 8;
    localparam int unsigned SPAN = LANE_W + CB_W;

    logic [LANES-1:0] lane_sum;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [MAX_SPAN-1:0] slice;
            assign slice = MAX_SPAN'({cbe[l*CB_W +: CB_W], ad[l*LANE_W +: LANE_W]});
            assign lane_sum[l] = odd_ones(slice);
        end
    endgenerate

    initial begin
        if (SPAN > MAX_SPAN) $error("lane span exceeds parity function width");
    end

    bpar_gen #(.LANES(LANES)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .src_any  (src_addr | src_data),
        .wide     (wide),
        .lane_sum (lane_sum),
        .par_out  (par_out),
        .par_oe   (par_oe)
    );

    bpar_chk #(.LANES(LANES)) u_chk_data (
        .clk      (clk),
        .rst      (rst),
        .sample   (chk_data),
        .wide     (wide),
        .lane_sum (lane_sum),
        .par_in   (par_in),
        .enable   (perr_en),
        .err_oe   (perr_oe)
    );

    bpar_chk #(.LANES(LANES)) u_chk_addr (
        .clk      (clk),
        .rst      (rst),
        .sample   (chk_addr),
        .wide     (wide),
        .lane_sum (lane_sum),
        .par_in   (par_in),
        .enable   (serr_en),
        .err_oe   (serr_oe)
    );

    a_r2_oe_follows_source: assert property (@(posedge clk) disable iff (rst)
        par_oe[0] |-> $past(src_addr || src_data));

    a_r4_perr_after_data: assert property (@(posedge clk) disable iff (rst)
        perr_oe |-> $past(chk_data, 2));

    a_r5_serr_after_addr: assert property (@(posedge clk) disable iff (rst)
        serr_oe |-> $past(chk_addr, 2));

    a_r6_perr_masked: assert property (@(posedge clk) disable iff (rst)
        !$past(perr_en) |-> !perr_oe);

    a_r7_serr_masked: assert property (@(posedge clk) disable iff (rst)
        !$past(serr_en) |-> !serr_oe);

endmodule

// File: tb/test_bus_parity_unit.sv
module test_bus_parity_unit;

    localparam int unsigned LW = 8;
    localparam int unsigned LN = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [15:0]   ad;
    logic [1:0]    cbe;
    logic [1:0]    par_in;
    logic          src_addr, src_data, chk_addr, chk_data, wide, perr_en, serr_en;
    logic [1:0]    par_out, par_oe;
    logic          perr_oe, serr_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bus_parity_unit #(.LANE_W(LW), .LANES(LN)) i_bus_parity_unit (
        .clk(clk), .rst(rst), .ad(ad), .cbe(cbe), .par_in(par_in),
        .src_addr(src_addr), .src_data(src_data), .chk_addr(chk_addr), .chk_data(chk_data),
        .wide(wide), .perr_en(perr_en), .serr_en(serr_en),
        .par_out(par_out), .par_oe(par_oe), .perr_oe(perr_oe), .serr_oe(serr_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst = 1; ad = '0; cbe = '0; par_in = '0;
        src_addr = 0; src_data = 0; chk_addr = 0; chk_data = 0;
        wide = 0; perr_en = 1; serr_en = 1;
        tick(); tick();
        // R8: outputs quiet during reset
        check("R8 par_oe", par_oe, 2'b00);
        check("R8 perr_oe", perr_oe, 0);
        check("R8 serr_oe", serr_oe, 0);
        rst = 0;
        tick();
        check("R8 after reset", {par_oe, perr_oe, serr_oe}, 0);

        // Generator sweep: R1, R2, R3
        for (int i = 0; i < 512; i++) begin
            logic [8:0] lo;
            logic [8:0] hi;
            logic       any;
            logic       w;
            lo = 9'(i);
            hi = 9'((i * 37 + 5) % 512);
            ad = {hi[7:0], lo[7:0]};
            cbe = {hi[8], lo[8]};
            src_addr = (i % 4 == 1) || (i % 4 == 3);
            src_data = (i % 4 == 2) || (i % 4 == 3);
            any = src_addr | src_data;
            w = ((i / 4) % 2 == 1);
            wide = w;
            tick();
            src_addr = 0; src_data = 0; wide = 0;
            check("R2 par_oe lane0", par_oe[0], any);
            if (any) check("R1 par_out lane0", par_out[0], ^lo);
            check("R3 par_oe lane1", par_oe[1], any & w);
            if (any & w) check("R3 par_out lane1", par_out[1], ^hi);
            tick();
            check("R2 par_oe idle", par_oe, 2'b00);
        end

        // Checker sweep: R4, R5, R6, R7, R9
        for (int i = 0; i < 512; i++) begin
            logic [8:0] lo;
            logic [8:0] hi;
            logic inj_lo, inj_hi, w, is_addr, pe, se, bad;
            lo = 9'(i);
            hi = 9'((i * 53 + 11) % 512);
            inj_lo = (i % 3 == 0);
            inj_hi = (i % 5 == 0);
            w = ((i / 2) % 2 == 1);
            is_addr = ((i / 4) % 2 == 1);
            pe = (i % 7 != 0);
            se = (i % 11 != 0);
            ad = {hi[7:0], lo[7:0]};
            cbe = {hi[8], lo[8]};
            wide = w;
            chk_addr = is_addr;
            chk_data = !is_addr;
            tick();
            chk_addr = 0; chk_data = 0; wide = 0;
            par_in = {(^hi) ^ inj_hi, (^lo) ^ inj_lo};
            perr_en = pe;
            serr_en = se;
            check("R4 no early perr", perr_oe, 0);
            check("R5 no early serr", serr_oe, 0);
            tick();
            bad = inj_lo | (w & inj_hi);
            // R9: upper-lane error ignored when not wide
            check("R4/R6/R9 perr_oe", perr_oe, !is_addr & pe & bad);
            check("R5/R7/R9 serr_oe", serr_oe, is_addr & se & bad);
            tick();
            check("R4 perr one cycle", perr_oe, 0);
            check("R5 serr one cycle", serr_oe, 0);
        end

        finish_run();
    end

endmodule